// File: doc/BRIEF.md
# Two-by-Two Routing Switch Cell

This cell is the basic element of a multistage interconnection network. It has two message inputs and two message outputs. Each port carries a valid/ready handshake. A message moves from an input to an output in the same cycle that the output accepts it, because the data path holds no registers. The cell chooses its connection in one of two ways. In self-routing mode, it reads one chosen bit of each message's module field. When self-routing is off, a two-bit state input selects one of four fixed states: straight, swapped, broadcast from the upper input, and broadcast from the lower input.

A message is one flat word. From the most significant end it holds the destination module number, the address inside that module, an operation code, and an operand value. In self-routing mode both inputs may target the same output. The cell then grants that output to one input and holds the other input with ready low. The choice alternates between the two inputs from one contested transfer to the next. A broadcast fans one input out to both outputs. The input sees ready only when both outputs have taken the message, and the two outputs may take it in different cycles.

Top module: `sw2_cell`

## Requirements
- R1: Message layout is {module[MOD_W], address[ADDR_W], opcode[OP_W], value[VAL_W]}, with module in the MSBs. When self_route is 1, a valid message whose module bit ROUTE_BIT is 0 is offered on output 0 (upper), and a message whose bit is 1 is offered on output 1 (lower). An uncontested input sees in_ready equal to that output's out_ready in the same cycle.
- R2: With self_route 0 and fixed_state 0 (straight), out_valid/out_data of output k follow in_valid/in_data of input k, and in_ready of input k equals out_ready of output k.
- R3: With fixed_state 1 (swapped), output 0 carries input 1 and output 1 carries input 0, and each input's ready follows the output it drives.
- R4: With fixed_state 2 (upper broadcast), input 0 is offered on both outputs, and input 1 sees in_ready 0.
- R5: With fixed_state 3 (lower broadcast), input 1 is offered on both outputs, and input 0 sees in_ready 0.
- R6: A broadcast input sees in_ready 1 only in the cycle that completes acceptance by both outputs. An output that has already taken the message drops out_valid until the input transfers. The next message is then offered on both outputs again.
- R7: When both valid inputs target the same output in self-routing, exactly one input is granted and the other input sees in_ready 0. After a contested transfer, the next contest for that output goes to the other input.
- R8: Once an output shows out_valid with out_ready low, it keeps out_valid and the same out_data until accepted, even if the other input starts requesting that output and would win the next contest.
- R9: After reset no output is valid, no broadcast is partially done, and input 0 wins the first contest on each output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_route | input | 1 | 1: route each message on its module bit; 0: use fixed_state |
| fixed_state | input | 2 | 0 straight, 1 swapped, 2 upper broadcast, 3 lower broadcast |
| in_valid | input | 2 | Message valid per input (bit 0 upper) |
| in_ready | output | 2 | Message taken per input |
| in_data | input | 2 x MSG_W | Message per input |
| out_valid | output | 2 | Message offered per output (bit 0 upper) |
| out_ready | input | 2 | Downstream accepts per output |
| out_data | output | 2 x MSG_W | Message per output |

## Verification
The cell's state is small: a priority bit and a lock per output, and two acceptance bits per input. A wrong value in any of these shows at the ports in the same or the next cycle. A stuck priority bit hands two contests in a row to the same input. A lost lock changes out_data during a stall. A stale acceptance bit either offers a broadcast message twice or releases the input early. The bench sweeps every state, valid pattern and ready pattern from a clean start. It also sweeps every pair of module values with a running model of the priority bits, so a faulty state is caught in the first cycle where it differs from the model.

// File: rtl/sw2_pkg.sv
package sw2_pkg;

  typedef enum logic [1:0] {
    ST_STRAIGHT = 2'd0,
    ST_SWAPPED  = 2'd1,
    ST_BC_UPPER = 2'd2,
    ST_BC_LOWER = 2'd3
  } sw_state_e;

  // Outputs requested by input idx in a fixed state (bit k = output k).
  function automatic logic [1:0] fixed_reqs(input sw_state_e st, input logic idx,
                                            input logic vld);
    logic [1:0] r;
    case (st)
      ST_STRAIGHT: r = idx ? 2'b10 : 2'b01;
      ST_SWAPPED:  r = idx ? 2'b01 : 2'b10;
      ST_BC_UPPER: r = idx ? 2'b00 : 2'b11;
      default:     r = idx ? 2'b11 : 2'b00;
    endcase
    return vld ? r : 2'b00;
  endfunction

  // Output requested by a self-routed input from its selected module bit.
  function automatic logic [1:0] auto_reqs(input logic dir_bit, input logic vld);
    if (!vld) return 2'b00;
    return dir_bit ? 2'b10 : 2'b01;
  endfunction

  // True for the input that a broadcast state silences.
  function automatic logic bc_silenced(input sw_state_e st, input logic idx);
    return (st == ST_BC_UPPER && idx) || (st == ST_BC_LOWER && !idx);
  endfunction

endpackage

// File: rtl/sw2_req_map.sv
module sw2_req_map
  import sw2_pkg::*;
#(
  parameter int MSG_W     = 45,
  parameter int ROUTE_POS = 44
) (
  input  logic                  self_route,
  input  logic [1:0]            fixed_state,
  input  logic [1:0]            in_valid,
  input  logic [1:0][MSG_W-1:0] in_data,
  output logic [1:0][1:0]       req,
  output logic [1:0]            hold
);

  sw_state_e st;
  assign st = sw_state_e'(fixed_state);

  for (genvar i = 0; i < 2; i++) begin : g_in
    logic dir_bit;
    assign dir_bit = in_data[i][ROUTE_POS];
    assign req[i]  = self_route ? auto_reqs(dir_bit, in_valid[i])
                                : fixed_reqs(st, 1'(i), in_valid[i]);
    assign hold[i] = !self_route && bc_silenced(st, 1'(i));
  end

endmodule

// File: rtl/sw2_out_arb.sv
module sw2_out_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] gnt
);

  logic prio_q;
  logic lock_vld_q;
  logic lock_src_q;
  logic contested;
  logic out_fire;
  logic out_stall;
  logic win;

  assign contested = &req;
  assign out_fire  = out_valid & out_ready;
  assign out_stall = out_valid & ~out_ready;
  assign win       = gnt[1];

  always_comb begin
    if (lock_vld_q)
      gnt = lock_src_q ? {req[1], 1'b0} : {1'b0, req[0]};
    else if (contested)
      gnt = prio_q ? 2'b10 : 2'b01;
    else
      gnt = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q     <= 1'b0;
      lock_vld_q <= 1'b0;
      lock_src_q <= 1'b0;
    end else if (out_fire) begin
      lock_vld_q <= 1'b0;
      if (contested) prio_q <= ~win;
    end else if (out_stall) begin
      lock_vld_q <= 1'b1;
      lock_src_q <= win;
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7
  alt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (contested && out_fire) |=> (!(&req) || (gnt[1] != $past(gnt[1]))));

endmodule

// File: rtl/sw2_fork_track.sv
module sw2_fork_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       hold,
  input  logic [1:0] req,
  input  logic [1:0] acc,
  output logic       ready,
  output logic [1:0] done
);

  logic fire;

  assign ready = !hold && (&(~req | done | acc));
  assign fire  = in_valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    done <= 2'b00;
    else if (fire) done <= 2'b00;
    else           done <= done | acc;
  end

  // R6
  single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(done & acc)));

endmodule

// File: rtl/sw2_cell.sv
module sw2_cell
  import sw2_pkg::*;
#(
  parameter int MOD_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int OP_W      = 2,
  parameter int VAL_W     = 32,
  parameter int ROUTE_BIT = 2,
  localparam int MSG_W    = MOD_W + ADDR_W + OP_W + VAL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  self_route,
  input  logic [1:0]            fixed_state,
  input  logic [1:0]            in_valid,
  output logic [1:0]            in_ready,
  input  logic [1:0][MSG_W-1:0] in_data,
  output logic [1:0]            out_valid,
  input  logic [1:0]            out_ready,
  output logic [1:0][MSG_W-1:0] out_data
);

  localparam int ROUTE_POS = VAL_W + OP_W + ADDR_W + ROUTE_BIT;

  logic [1:0][1:0] req;   // [input][output]
  logic [1:0]      hold;
  logic [1:0][1:0] gnt;   // [output][input]
  logic [1:0][1:0] done;  // [input][output]
  logic [1:0][1:0] acc;   // [input][output]

  sw2_req_map #(.MSG_W(MSG_W), .ROUTE_POS(ROUTE_POS)) u_map (
    .self_route  (self_route),
    .fixed_state (fixed_state),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .req         (req),
    .hold        (hold)
  );

  for (genvar k = 0; k < 2; k++) begin : g_out
    sw2_out_arb u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       ({req[1][k], req[0][k]}),
      .out_valid (out_valid[k]),
      .out_ready (out_ready[k]),
      .gnt       (gnt[k])
    );

    assign out_valid[k] = (gnt[k][0] & ~done[0][k]) | (gnt[k][1] & ~done[1][k]);
    assign out_data[k]  = gnt[k][1] ? in_data[1] : in_data[0];

    for (genvar i = 0; i < 2; i++) begin : g_acc
      assign acc[i][k] = gnt[k][i] & out_valid[k] & out_ready[k];
    end

    // R1
    route_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (self_route && out_valid[k]) |-> (out_data[k][ROUTE_POS] == 1'(k)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && !out_ready[k]) |=> (out_valid[k] && $stable(out_data[k])));

    // R2
    straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!self_route && fixed_state == 2'd0 && out_valid[k]) |->
        (in_valid[k] && out_data[k] == in_data[k]));
  end

  for (genvar i = 0; i < 2; i++) begin : g_in
    sw2_fork_track u_fork (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[i]),
      .hold     (hold[i]),
      .req      (req[i]),
      .acc      (acc[i]),
      .ready    (in_ready[i]),
      .done     (done[i])
    );
  end

endmodule

// File: tb/test_sw2_cell.sv
module test_sw2_cell;

  localparam int CLK_P  = 10;
  localparam int MOD_W  = 3;
  localparam int ADDR_W = 4;
  localparam int OP_W   = 2;
  localparam int VAL_W  = 8;
  localparam int RB     = 1;
  localparam int MSG_W  = MOD_W + ADDR_W + OP_W + VAL_W;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  self_route = 1'b0;
  logic [1:0]            fixed_state = 2'd0;
  logic [1:0]            in_valid = 2'b00;
  logic [1:0]            in_ready;
  logic [1:0][MSG_W-1:0] in_data = '0;
  logic [1:0]            out_valid;
  logic [1:0]            out_ready = 2'b00;
  logic [1:0][MSG_W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sw2_cell #(.MOD_W(MOD_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .VAL_W(VAL_W),
             .ROUTE_BIT(RB)) i_sw2_cell (
    .clk(clk), .rst_n(rst_n), .self_route(self_route), .fixed_state(fixed_state),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [MSG_W-1:0] mk(input logic [MOD_W-1:0] m,
      input logic [ADDR_W-1:0] a, input logic [OP_W-1:0] o, input logic [VAL_W-1:0] v);
    return {m, a, o, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 2'b00;
    out_ready = 2'b00;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] prio;
    logic [1:0] prio_nx;
    logic [MSG_W-1:0] m0;
    logic [MSG_W-1:0] m1;

    do_reset();
    #1;
    chk("R9 idle out_valid", 32'(out_valid), 32'd0);

    // Fixed states: every valid and ready pattern from a clean start
    for (int st = 0; st < 4; st++) begin
      for (int v = 0; v < 4; v++) begin
        for (int r = 0; r < 4; r++) begin
          logic [1:0] ev;
          logic [1:0] er;
          logic [1:0] vb;
          logic [1:0] rb;
          do_reset();
          vb = 2'(v);
          rb = 2'(r);
          self_route = 1'b0;
          fixed_state = 2'(st);
          in_data[0] = mk(3'(v), 4'(r), 2'(st), 8'h3C);
          in_data[1] = mk(3'(r), 4'(v), 2'(st), 8'hC5);
          in_valid = vb;
          out_ready = rb;
          #1;
          for (int k = 0; k < 2; k++) begin
            int src;
            case (st)
              0: src = k;
              1: src = 1 - k;
              2: src = 0;
              default: src = 1;
            endcase
            ev[k] = vb[src];
            chk($sformatf("R%0d out_valid[%0d] st%0d", (st < 2) ? st + 2 : st + 2, k, st),
                32'(out_valid[k]), 32'(ev[k]));
            if (ev[k]) chk((st == 0) ? "R2 data" : (st == 1) ? "R3 data" :
                           (st == 2) ? "R4 data" : "R5 data",
                           32'(out_data[k]), 32'(in_data[src]));
          end
          case (st)
            0: er = rb;
            1: er = {rb[0], rb[1]};
            2: er = {1'b0, &rb};
            default: er = {&rb, 1'b0};
          endcase
          for (int i = 0; i < 2; i++) begin
            if (vb[i]) chk((st == 0) ? "R2 ready" : (st == 1) ? "R3 ready" :
                           (st == 2) ? "R4 ready" : "R5 ready",
                           32'(in_ready[i]), 32'(er[i]));
          end
        end
      end
    end

    // Broadcast accepted by the outputs in separate cycles
    do_reset();
    self_route = 1'b0;
    fixed_state = 2'd2;
    m0 = mk(3'd5, 4'd9, 2'd1, 8'h77);
    in_data[0] = m0;
    in_data[1] = mk(3'd1, 4'd1, 2'd1, 8'h11);
    in_valid = 2'b01;
    out_ready = 2'b01;
    #1;
    chk("R6 both offered", 32'(out_valid), 32'b11);
    chk("R6 no early ready", 32'(in_ready[0]), 32'd0);
    @(negedge clk);
    out_ready = 2'b10;
    #1;
    chk("R6 taken output drops", 32'(out_valid), 32'b10);
    chk("R6 ready on second", 32'(in_ready[0]), 32'd1);
    chk("R6 second data", 32'(out_data[1]), 32'(m0));
    @(negedge clk);
    m1 = mk(3'd6, 4'd2, 2'd2, 8'h5A);
    in_data[0] = m1;
    out_ready = 2'b00;
    #1;
    chk("R6 next offered to both", 32'(out_valid), 32'b11);
    chk("R6 next data", 32'(out_data[0]), 32'(m1));
    do_reset();

    // Self-routing sweep over all module pairs with a priority model
    self_route = 1'b1;
    prio = 2'b00;
    for (int v = 1; v < 4; v++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          logic [1:0] vb;
          logic [1:0] dst;
          @(negedge clk);
          vb = 2'(v);
          in_data[0] = mk(3'(a), 4'(b), 2'd1, 8'(a * 16 + b));
          in_data[1] = mk(3'(b), 4'(a), 2'd2, 8'(b * 16 + a + 7));
          in_valid = vb;
          out_ready = 2'b11;
          dst[0] = a[RB];
          dst[1] = b[RB];
          prio_nx = prio;
          #1;
          for (int k = 0; k < 2; k++) begin
            logic rq0;
            logic rq1;
            logic w;
            rq0 = vb[0] && (dst[0] == 1'(k));
            rq1 = vb[1] && (dst[1] == 1'(k));
            w = (rq0 && rq1) ? prio[k] : rq1;
            chk("R1 out_valid", 32'(out_valid[k]), 32'(rq0 | rq1));
            if (rq0 | rq1) chk("R1 out_data", 32'(out_data[k]), 32'(in_data[w]));
            if (rq0 && rq1) begin
              chk("R7 winner ready", 32'(in_ready[w]), 32'd1);
              chk("R7 loser held", 32'(in_ready[!w]), 32'd0);
              prio_nx[k] = !w;
            end else if (rq0 | rq1) begin
              chk("R1 single ready", 32'(in_ready[w]), 32'd1);
            end
          end
          prio = prio_nx;
        end
      end
    end

    // Stall lock: a waiting output keeps its message against a new contender
    do_reset();
    self_route = 1'b1;
    m0 = mk(3'd0, 4'd1, 2'd0, 8'h21);
    m1 = mk(3'd4, 4'd2, 2'd0, 8'h42);
    in_data[0] = m0;
    in_data[1] = m1;
    in_valid = 2'b11;
    out_ready = 2'b11;
    #1;
    chk("R9 first contest to input 0", 32'(in_ready), 32'b01);
    @(negedge clk);
    m0 = mk(3'd0, 4'd3, 2'd1, 8'h63);
    in_data[0] = m0;
    in_valid = 2'b01;
    out_ready = 2'b00;
    #1;
    chk("R8 offered", 32'(out_data[0]), 32'(m0));
    @(negedge clk);
    in_valid = 2'b11;
    #1;
    chk("R8 held data", 32'(out_data[0]), 32'(m0));
    chk("R8 contender held", 32'(in_ready[1]), 32'd0);
    @(negedge clk);
    out_ready = 2'b01;
    #1;
    chk("R8 held until taken", 32'(out_data[0]), 32'(m0));
    chk("R8 owner ready", 32'(in_ready), 32'b01);
    @(negedge clk);
    in_valid = 2'b10;
    #1;
    chk("R7 contender served", 32'(out_data[0]), 32'(m1));
    chk("R7 contender ready", 32'(in_ready[1]), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule